// File: doc/BRIEF.md
# Tagged Next-Line Prefetch Controller

This block sits beside a small direct-mapped cache and decides when to fetch the line that follows the one being accessed. It keeps its own directory of the cache: a valid bit, the tag and one extra bit per set. The extra bit is the "unused prefetch" flag, and it marks a line that a prefetch brought in and that no access has yet referenced. Each access presents a line address and the cache's hit/miss result. From these and the directory, the controller may start a request for line L+1 on a valid/ready port. The cache reports every completed fill back to the controller, with a flag that says whether the fill was a prefetch or a demand fetch.

A mode input selects between two policies. In prefetch-on-miss mode, only a missing access starts a lookahead. In tagged mode, a request is also started on the first use of a line, which is either a demand miss or the first hit on a line whose flag is still set. The controller never requests a line the directory already holds. It keeps at most one prefetch in flight, from the moment it raises the request until the matching prefetch fill returns. Triggers that arrive in that window are discarded.

Top module: `tagged_obl_prefetch`

## Requirements
- R1: After reset the request output is low and the directory holds no line, so the first missing access in either mode requests the next line.
- R2: With `mode`=0 (prefetch-on-miss), an access with `acc_hit`=0 to line L raises `req_valid` on the next cycle with `req_line` = L+1 modulo 2^LINE_W. An access with `acc_hit`=1 never starts a request in this mode, even when it hits a flagged line.
- R3: With `mode`=1 (tagged), a missing access starts a request for L+1. So does a hit on a line that the directory holds with its flag set. A hit on a line whose flag is 0 starts no request.
- R4: A fill with `fill_pf`=1 into a set that does not hold that line installs it with the flag set. A fill with `fill_pf`=0 installs the line with the flag clear. The first hit on a flagged line clears the flag, so a second hit on it starts nothing.
- R5: No request is started when line L+1 is already in the directory.
- R6: Only one prefetch is in flight. The window runs from the cycle `req_valid` rises until a fill with `fill_pf`=1 and `fill_line` equal to the requested line. Triggers inside the window are dropped and are not replayed after it closes.
- R7: While `req_ready` is low, `req_valid` stays high and `req_line` stays unchanged. The cycle after a handshake, `req_valid` is low.
- R8: A prefetch fill whose line the directory already holds leaves that line's flag unchanged, so a line that a demand fill placed first stays unflagged.
- R9: The directory is direct-mapped on the low log2(SETS) bits of the line address. A fill replaces whatever line that set held, and the replaced line then counts as absent.
- R10: When an access and a fill arrive in the same cycle, the lookahead presence test uses the directory as it stood before that cycle. The fill is still written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = prefetch on miss, 1 = tagged prefetch |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_line | input | LINE_W | Line address of the access |
| acc_hit | input | 1 | Cache result of the access: 1 = hit |
| req_valid | output | 1 | Prefetch request pending |
| req_line | output | LINE_W | Line address to prefetch |
| req_ready | input | 1 | Memory side accepts the request |
| fill_valid | input | 1 | A line fill completed in the cache |
| fill_line | input | LINE_W | Line address of the completed fill |
| fill_pf | input | 1 | 1 = the fill answered a prefetch, 0 = demand fill |

## Verification
The bench builds the block with LINE_W=8 and SETS=8. This makes the address wrap from line 0xFF to 0x00 reachable in one access. It also lets two lines collide in a set by differing only in bit 3 and up, so replacement, re-request of an evicted neighbour and stale-flag cases appear within a few dozen cycles. A random phase over a narrow address window then mixes mode changes, stalled handshakes, duplicate fills and same-cycle access-and-fill. A behavioural model built on plain arrays is compared against the request port on every clock.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

   typedef enum logic {
      PF_ON_MISS = 1'b0,
      PF_TAGGED  = 1'b1
   } pf_mode_e;

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/pfx_line_dir.sv
module pfx_line_dir #(
   parameter int LINE_W = 20,
   parameter int SETS   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] look_a,
   input  logic [LINE_W-1:0] look_b,
   output logic              a_match,
   output logic              a_flag,
   output logic              b_present,
   input  logic              clr_a,
   input  logic              fill_valid,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              fill_pf
);
   localparam int IDX_W = $clog2(SETS);
   localparam int TAG_W = LINE_W - IDX_W;

   if (!pfx_pkg::is_pow2(SETS) || SETS < 2) begin : g_bad_sets
      $error("pfx_line_dir: SETS must be a power of two of at least 2");
   end
   if (LINE_W <= IDX_W) begin : g_bad_width
      $error("pfx_line_dir: LINE_W must exceed log2(SETS)");
   end

   logic [SETS-1:0]  v_vec;
   logic [SETS-1:0]  pf_vec;
   logic [TAG_W-1:0] tag_vec [SETS];

   logic [IDX_W-1:0] a_idx, b_idx, f_idx;
   logic [TAG_W-1:0] a_tag, b_tag, f_tag;

   assign a_idx = look_a[IDX_W-1:0];
   assign a_tag = look_a[LINE_W-1:IDX_W];
   assign b_idx = look_b[IDX_W-1:0];
   assign b_tag = look_b[LINE_W-1:IDX_W];
   assign f_idx = fill_line[IDX_W-1:0];
   assign f_tag = fill_line[LINE_W-1:IDX_W];

   assign a_match   = v_vec[a_idx] && (tag_vec[a_idx] == a_tag);
   assign a_flag    = pf_vec[a_idx];
   assign b_present = v_vec[b_idx] && (tag_vec[b_idx] == b_tag);

   for (genvar s = 0; s < SETS; s++) begin : g_set
      logic             v_r;
      logic             pf_r;
      logic [TAG_W-1:0] tag_r;
      logic             fill_here;
      logic             clr_here;
      logic             same_line;
      logic             pf_nxt;

      assign fill_here = fill_valid && (f_idx == IDX_W'(s));
      assign clr_here  = clr_a && (a_idx == IDX_W'(s));
      assign same_line = v_r && (tag_r == f_tag);

      always_comb begin
         pf_nxt = pf_r & ~clr_here;
         if (fill_here) begin
            if (!fill_pf)
               pf_nxt = 1'b0;
            else if (!same_line)
               pf_nxt = 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_r   <= 1'b0;
            pf_r  <= 1'b0;
            tag_r <= '0;
         end else begin
            pf_r <= pf_nxt;
            if (fill_here) begin
               v_r   <= 1'b1;
               tag_r <= f_tag;
            end
         end
      end

      assign v_vec[s]   = v_r;
      assign pf_vec[s]  = pf_r;
      assign tag_vec[s] = tag_r;
   end

   AST_DEMAND_FILL_UNFLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid && !fill_pf |=> !pf_vec[$past(f_idx)]); // R4

   AST_FIRST_USE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_a && !(fill_valid && f_idx == a_idx) |=> !pf_vec[$past(a_idx)]); // R4

   AST_FILL_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> v_vec[$past(f_idx)] && tag_vec[$past(f_idx)] == $past(f_tag)); // R9

endmodule

// File: rtl/pfx_trigger.sv
module pfx_trigger (
   input  logic mode,
   input  logic acc_valid,
   input  logic acc_hit,
   input  logic a_match,
   input  logic a_flag,
   input  logic b_present,
   input  logic busy,
   output logic fire,
   output logic first_use
);
   import pfx_pkg::*;

   logic miss;
   logic want;

   assign miss      = acc_valid && !acc_hit;
   assign first_use = acc_valid && acc_hit && a_match && a_flag;

   always_comb begin
      unique case (pf_mode_e'(mode))
         PF_ON_MISS: want = miss;
         PF_TAGGED:  want = miss || first_use;
         default:    want = 1'b0;
      endcase
   end

   assign fire = want && !busy && !b_present;

endmodule

// File: rtl/pfx_req_port.sv
module pfx_req_port #(
   parameter int LINE_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [LINE_W-1:0] fire_line,
   input  logic              req_ready,
   input  logic              fill_valid,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              fill_pf,
   output logic              req_valid,
   output logic [LINE_W-1:0] req_line,
   output logic              busy
);
   logic wait_fill;

   assign busy = req_valid || wait_fill;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_valid <= 1'b0;
         req_line  <= '0;
         wait_fill <= 1'b0;
      end else begin
         if (req_valid && req_ready) begin
            req_valid <= 1'b0;
            wait_fill <= 1'b1;
         end else if (fire) begin
            req_valid <= 1'b1;
            req_line  <= fire_line;
         end
         if (wait_fill && fill_valid && fill_pf && fill_line == req_line)
            wait_fill <= 1'b0;
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_line)); // R7

   AST_REQ_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_valid); // R7

   AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> $past(!wait_fill)); // R6

endmodule

// File: rtl/tagged_obl_prefetch.sv
module tagged_obl_prefetch #(
   parameter int LINE_W = 20,
   parameter int SETS   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode,
   input  logic              acc_valid,
   input  logic [LINE_W-1:0] acc_line,
   input  logic              acc_hit,
   output logic              req_valid,
   output logic [LINE_W-1:0] req_line,
   input  logic              req_ready,
   input  logic              fill_valid,
   input  logic [LINE_W-1:0] fill_line,
   input  logic              fill_pf
);
   import pfx_pkg::*;

   logic [LINE_W-1:0] next_line;
   logic              a_match, a_flag, b_present;
   logic              busy, fire, first_use;

   assign next_line = acc_line + LINE_W'(1);

   pfx_line_dir #(.LINE_W(LINE_W), .SETS(SETS)) u_dir (
      .clk        (clk),
      .rst_n      (rst_n),
      .look_a     (acc_line),
      .look_b     (next_line),
      .a_match    (a_match),
      .a_flag     (a_flag),
      .b_present  (b_present),
      .clr_a      (first_use),
      .fill_valid (fill_valid),
      .fill_line  (fill_line),
      .fill_pf    (fill_pf)
   );

   pfx_trigger u_trig (
      .mode      (mode),
      .acc_valid (acc_valid),
      .acc_hit   (acc_hit),
      .a_match   (a_match),
      .a_flag    (a_flag),
      .b_present (b_present),
      .busy      (busy),
      .fire      (fire),
      .first_use (first_use)
   );

   pfx_req_port #(.LINE_W(LINE_W)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire       (fire),
      .fire_line  (next_line),
      .req_ready  (req_ready),
      .fill_valid (fill_valid),
      .fill_line  (fill_line),
      .fill_pf    (fill_pf),
      .req_valid  (req_valid),
      .req_line   (req_line),
      .busy       (busy)
   );

   AST_NEXT_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> $past(acc_valid) && req_line == $past(next_line)); // R2

   AST_MISS_MODE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) && $past(mode == PF_ON_MISS) |-> $past(!acc_hit)); // R2

   AST_NOT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_valid) |-> $past(!b_present)); // R5

endmodule

// File: tb/tagged_obl_prefetch_test.sv
module tagged_obl_prefetch_test;
   localparam int LW = 8;
   localparam int NS = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode = 1'b1;
   logic          acc_valid = 1'b0;
   logic [LW-1:0] acc_line = '0;
   logic          acc_hit = 1'b0;
   logic          req_valid;
   logic [LW-1:0] req_line;
   logic          req_ready = 1'b0;
   logic          fill_valid = 1'b0;
   logic [LW-1:0] fill_line = '0;
   logic          fill_pf = 1'b0;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;

   always #4 clk = ~clk;

   tagged_obl_prefetch #(.LINE_W(LW), .SETS(NS)) uut (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .acc_valid(acc_valid), .acc_line(acc_line), .acc_hit(acc_hit),
      .req_valid(req_valid), .req_line(req_line), .req_ready(req_ready),
      .fill_valid(fill_valid), .fill_line(fill_line), .fill_pf(fill_pf)
   );

   // behavioural model: plain arrays indexed by set
   bit            mv  [NS];
   bit            mpf [NS];
   int            mtag[NS];
   bit            mreq;
   bit            mwait;
   logic [LW-1:0] mline;

   always @(posedge clk) begin
      logic [LW-1:0] nl;
      int  ai, ni, fi;
      bit  amatch, npres, fuse, want, obusy, same, owait;
      logic [LW-1:0] oline;
      if (!rst_n) begin
         for (int s = 0; s < NS; s++) begin
            mv[s] = 0; mpf[s] = 0; mtag[s] = 0;
         end
         mreq = 0; mwait = 0; mline = '0;
      end else begin
         nl     = acc_line + 8'd1;
         ai     = int'(acc_line) % NS;
         ni     = int'(nl) % NS;
         fi     = int'(fill_line) % NS;
         amatch = mv[ai] && mtag[ai] == int'(acc_line) / NS;
         npres  = mv[ni] && mtag[ni] == int'(nl) / NS;
         fuse   = acc_valid && acc_hit && amatch && mpf[ai];
         want   = (acc_valid && !acc_hit) || (mode && fuse);
         obusy  = mreq || mwait;
         owait  = mwait;
         oline  = mline;
         same   = mv[fi] && mtag[fi] == int'(fill_line) / NS;
         if (mreq && req_ready) begin
            mreq = 0; mwait = 1;
         end else if (want && !obusy && !npres) begin
            mreq = 1; mline = nl;
         end
         if (owait && fill_valid && fill_pf && fill_line == oline) mwait = 0;
         if (fuse) mpf[ai] = 0;
         if (fill_valid) begin
            if (!fill_pf) mpf[fi] = 0;
            else if (!same) mpf[fi] = 1;
            mv[fi] = 1;
            mtag[fi] = int'(fill_line) / NS;
         end
      end
   end

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && cmp_on && !done) begin
         checks++;
         if (req_valid !== mreq || (mreq && req_line !== mline)) begin
            failures++;
            $display("FAIL R2 R3 R6 R7 model: req_valid=%0b req_line=%02h expected req_valid=%0b req_line=%02h",
                     req_valid, req_line, mreq, mline);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_req(input bit v, input logic [LW-1:0] l, input string tag);
      checks++;
      if (req_valid !== v || (v && req_line !== l)) begin
         failures++;
         $display("FAIL %s: req_valid=%0b req_line=%02h expected req_valid=%0b req_line=%02h",
                  tag, req_valid, req_line, v, l);
      end
   endtask

   task automatic access(input logic [LW-1:0] l, input bit h);
      acc_valid = 1; acc_line = l; acc_hit = h;
      tick();
      acc_valid = 0;
   endtask

   task automatic fill(input logic [LW-1:0] l, input bit p);
      fill_valid = 1; fill_line = l; fill_pf = p;
      tick();
      fill_valid = 0;
   endtask

   task automatic handshake();
      req_ready = 1;
      tick();
      req_ready = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         failures++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      cmp_on = 1;
      expect_req(0, '0, "R1 reset");

      // tagged mode
      mode = 1;
      access(8'h10, 0);  expect_req(1, 8'h11, "R1 R3 first miss");
      tick();            expect_req(1, 8'h11, "R7 hold while stalled");
      access(8'h20, 0);  expect_req(1, 8'h11, "R6 trigger dropped");
      handshake();       expect_req(0, '0, "R7 retire after handshake");
      access(8'h30, 0);  expect_req(0, '0, "R6 waiting for fill");
      fill(8'h10, 0);
      fill(8'h11, 1);    expect_req(0, '0, "R6 not replayed");
      access(8'h11, 1);  expect_req(1, 8'h12, "R3 R4 flagged first hit");
      handshake();
      fill(8'h12, 1);
      access(8'h11, 1);  expect_req(0, '0, "R4 flag cleared");
      access(8'h10, 1);  expect_req(0, '0, "R3 unflagged hit");
      access(8'h11, 0);  expect_req(0, '0, "R5 next line present");
      access(8'h22, 0);  expect_req(1, 8'h23, "R3 miss request");
      handshake();
      fill(8'h23, 0);
      fill(8'h23, 1);
      access(8'h23, 1);  expect_req(0, '0, "R8 late prefetch fill");
      access(8'h44, 0);  expect_req(1, 8'h45, "R6 window closed");
      handshake();
      fill(8'h45, 1);

      // replacement, prefetch-on-miss mode
      fill(8'h19, 0);
      mode = 0;
      access(8'h10, 0);  expect_req(1, 8'h11, "R9 R2 evicted neighbour");
      handshake();
      fill(8'h11, 1);
      access(8'h11, 1);  expect_req(0, '0, "R2 hit ignored in miss mode");
      access(8'hFF, 0);  expect_req(1, 8'h00, "R2 address wrap");
      handshake();
      fill(8'h00, 1);

      // same-cycle access and fill
      acc_valid = 1; acc_line = 8'h06; acc_hit = 0;
      fill_valid = 1; fill_line = 8'h07; fill_pf = 0;
      tick();
      acc_valid = 0; fill_valid = 0;
      expect_req(1, 8'h07, "R10 presence uses prior state");
      handshake();
      fill(8'h07, 1);
      mode = 1;
      access(8'h07, 1);  expect_req(0, '0, "R10 fill written unflagged");

      // random phase
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 3) mode = ~mode;
         acc_valid = ($urandom_range(0, 1) == 1);
         if ($urandom_range(0, 3) == 0)
            acc_line = 8'hF8 + 8'($urandom_range(0, 7));
         else
            acc_line = 8'($urandom_range(0, 40));
         acc_hit = ($urandom_range(0, 2) != 0);
         req_ready = ($urandom_range(0, 1) == 1);
         fill_valid = ($urandom_range(0, 9) < 3);
         if (mwait && $urandom_range(0, 1) == 1) begin
            fill_line = mline; fill_pf = 1;
         end else begin
            fill_line = 8'($urandom_range(0, 48));
            fill_pf = ($urandom_range(0, 1) == 1);
         end
         tick();
      end
      acc_valid = 0; fill_valid = 0; req_ready = 0;
      tick();

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule